// File: doc/BRIEF.md
# Dual-Port Lock and Mailbox Channel Bank

This block sits between two processor cores and gives them a bank of channels for safe sharing. Each channel holds a lock and a data word. A core takes a lock by reading the channel's acquire address. The read returns a success flag, and the channel records the requester's ID as owner. Only that owner may then change the data word or give the lock back. A core can also read a status word that shows, for each channel, whether it is held and by which ID.

Next to the channels is a set of notification lines. Each line has one pending bit toward each core. A core raises a line toward its peer by writing that line's set address. The receiving core writes the line's clear address to drop its own pending bit. The lines drive interrupt outputs directly. A message exchange pairs a channel with a line: the sender locks the channel, writes the word and raises the line, and the receiver answers by raising a line back.

Each core has a plain register port. A request is one cycle with `cN_valid` high. The port accepts a request on every cycle and has no back-pressure. A read answers one cycle later on `cN_rvalid`/`cN_rdata`. A write produces no response. The address is 8 bits: bits 7:4 select a region and bits 3:0 select the channel or line. The regions are:

| Region | Code | Read | Write |
|--------|------|------|-------|
| acquire | 0 | attempt to take the lock | no effect |
| data | 1 | the channel's data word | store the word (owner only) |
| release | 2 | zero | free the lock (owner only) |
| set | 3 | zero | raise the line toward the other core |
| clear | 4 | this core's pending bitmap | clear the line toward this core |
| status | 5 | lock bit and owner of one channel | no effect |
| lock map | 6 | lock bits of all channels | no effect |

Top module: `mbx_array`

## Requirements
- R1: A read of region 0, index n, when channel n is free returns 0x8000_0000. The channel then becomes locked and its owner is the requester's `cN_id`. Every read answers with `cN_rvalid` high in the cycle after the request, and a write never raises `cN_rvalid`.
- R2: A read of region 0 on a channel that is already locked returns 0 and changes neither the lock nor the owner. This holds even when the reader is the owner.
- R3: When both ports read region 0 of the same free channel in the same cycle, port 0 gets 0x8000_0000 and becomes the owner, and port 1 gets 0.
- R4: A write to region 1, index n, stores `cN_wdata` only when channel n is locked and `cN_id` equals the owner. If both ports qualify in one cycle, port 0's word is kept. A read of region 1 by either port returns the stored word. After reset every data word is 0.
- R5: A write to region 2, index n, by the owner frees channel n and sets its owner to 0. A write to region 2 from any other ID changes nothing.
- R6: A read of region 5, index n, returns bit 31 = lock bit and bits 3:0 = owner ID, with all other bits 0. A read of region 6 returns the lock bits of channels 15..0 in bits 15:0.
- R7: A write from port p to region 3, index n, sets bit n of the interrupt output of the other port. The bit stays high until that other port clears it.
- R8: A write from port p to region 4, index n, clears bit n of port p's own interrupt output. If a set and a clear hit the same bit in the same cycle, the set wins. A read of region 4 returns the reading port's pending bitmap.
- R9: After reset every channel is free with owner 0 and both interrupt outputs are 0. Writes to regions 0, 5 and 6 have no effect. Reads of regions 2, 3 and 7 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| c0_valid | input | 1 | port 0 request strobe |
| c0_write | input | 1 | port 0: 1 = write, 0 = read |
| c0_addr | input | 8 | port 0 region and index |
| c0_wdata | input | 32 | port 0 write data |
| c0_id | input | 4 | port 0 requester ID |
| c0_rvalid | output | 1 | port 0 read response valid |
| c0_rdata | output | 32 | port 0 read response data |
| c1_valid | input | 1 | port 1 request strobe |
| c1_write | input | 1 | port 1: 1 = write, 0 = read |
| c1_addr | input | 8 | port 1 region and index |
| c1_wdata | input | 32 | port 1 write data |
| c1_id | input | 4 | port 1 requester ID |
| c1_rvalid | output | 1 | port 1 read response valid |
| c1_rdata | output | 32 | port 1 read response data |
| irq_c0 | output | 16 | pending notification lines toward core 0 |
| irq_c1 | output | 16 | pending notification lines toward core 1 |

## Verification
Every result of this block is due exactly one clock edge after the request. A read response appears on `cN_rvalid`/`cN_rdata`, and a lock, data, release, set or clear appears in the state and on `irq_c0`/`irq_c1`. The bench drives each request on a falling edge. It compares the response and both interrupt vectors on the next falling edge, just after the single edge that applies the request. It then updates its model of locks, owners, words and pending bits. A read issued in the following cycle therefore sees the state as it stood before that read's own edge, and the expected value is taken from the model as it was before the update.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [3:0] RG_ACQ  = 4'd0;
  localparam logic [3:0] RG_DATA = 4'd1;
  localparam logic [3:0] RG_REL  = 4'd2;
  localparam logic [3:0] RG_SET  = 4'd3;
  localparam logic [3:0] RG_CLR  = 4'd4;
  localparam logic [3:0] RG_STAT = 4'd5;
  localparam logic [3:0] RG_MAP  = 4'd6;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic           valid,
  input  logic           write,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] acq,
  output logic [NCH-1:0] wr,
  output logic [NCH-1:0] rel,
  output logic [NCH-1:0] set,
  output logic [NCH-1:0] clr
);
  localparam int IW = AW - 4;
  logic [3:0]    rg;
  logic [IW-1:0] idx;
  assign rg  = addr[AW-1:IW];
  assign idx = addr[IW-1:0];

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    logic hit;
    assign hit    = valid && (idx == IW'(n));
    assign acq[n] = hit && !write && (rg == RG_ACQ);
    assign wr[n]  = hit &&  write && (rg == RG_DATA);
    assign rel[n] = hit &&  write && (rg == RG_REL);
    assign set[n] = hit &&  write && (rg == RG_SET);
    assign clr[n] = hit &&  write && (rg == RG_CLR);
  end
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int DW  = 32,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acq0,
  input  logic           acq1,
  input  logic           wr0,
  input  logic           wr1,
  input  logic           rel0,
  input  logic           rel1,
  input  logic [IDW-1:0] id0,
  input  logic [IDW-1:0] id1,
  input  logic [DW-1:0]  wdata0,
  input  logic [DW-1:0]  wdata1,
  output logic           grant0,
  output logic           grant1,
  output logic           locked,
  output logic [IDW-1:0] owner,
  output logic [DW-1:0]  data
);
  logic own0, own1;
  assign own0   = locked && (owner == id0);
  assign own1   = locked && (owner == id1);
  // port 0 takes precedence on a same-cycle acquire
  assign grant0 = acq0 && !locked;
  assign grant1 = acq1 && !locked && !acq0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      data   <= '0;
    end else begin
      if (wr0 && own0)      data <= wdata0;
      else if (wr1 && own1) data <= wdata1;
      if (grant0) begin
        locked <= 1'b1;
        owner  <= id0;
      end else if (grant1) begin
        locked <= 1'b1;
        owner  <= id1;
      end else if ((rel0 && own0) || (rel1 && own1)) begin
        locked <= 1'b0;
        owner  <= '0;
      end
    end
  end

  a_r3_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acq0 && acq1 && !locked) |=> (locked && owner == $past(id0)));
  a_r2_held_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(rel0 && own0) && !(rel1 && own1)) |=> (locked && $stable(owner)));
  a_r4_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr0 && own0) && !(wr1 && own1)) |=> $stable(data));
  a_r5_owner_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rel0 && own0) |=> (!locked && owner == '0));
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant0 && grant1));
endmodule

// File: rtl/mbx_notify.sv
module mbx_notify #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set0,
  input  logic [NCH-1:0] set1,
  input  logic [NCH-1:0] clr0,
  input  logic [NCH-1:0] clr1,
  output logic [NCH-1:0] pend0,
  output logic [NCH-1:0] pend1
);
  // a port's set raises the peer's line; its clear drops its own line
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend0 <= '0;
      pend1 <= '0;
    end else begin
      pend0 <= set1 | (pend0 & ~clr0);
      pend1 <= set0 | (pend1 & ~clr1);
    end
  end

  a_r7_hold_c0: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend0 & $past(pend0 & ~clr0)) == $past(pend0 & ~clr0)));
  a_r8_set_wins_c1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend1 & $past(set0)) == $past(set0)));
  a_r8_clear_c1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend1 & $past(clr1 & ~set0)) == '0));
endmodule

// File: rtl/mbx_array.sv
module mbx_array
  import mbx_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32,
  parameter int IDW = 4,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           c0_valid,
  input  logic           c0_write,
  input  logic [AW-1:0]  c0_addr,
  input  logic [DW-1:0]  c0_wdata,
  input  logic [IDW-1:0] c0_id,
  output logic           c0_rvalid,
  output logic [DW-1:0]  c0_rdata,
  input  logic           c1_valid,
  input  logic           c1_write,
  input  logic [AW-1:0]  c1_addr,
  input  logic [DW-1:0]  c1_wdata,
  input  logic [IDW-1:0] c1_id,
  output logic           c1_rvalid,
  output logic [DW-1:0]  c1_rdata,
  output logic [NCH-1:0] irq_c0,
  output logic [NCH-1:0] irq_c1
);
  localparam int IW = AW - 4;

  logic [NCH-1:0] acq0, wr0, rel0, set0, clr0;
  logic [NCH-1:0] acq1, wr1, rel1, set1, clr1;
  logic [NCH-1:0] grant0, grant1, locked;
  logic [IDW-1:0] owner [NCH];
  logic [DW-1:0]  data  [NCH];

  mbx_port_dec #(.NCH(NCH), .AW(AW)) u_dec0 (
    .valid(c0_valid), .write(c0_write), .addr(c0_addr),
    .acq(acq0), .wr(wr0), .rel(rel0), .set(set0), .clr(clr0));
  mbx_port_dec #(.NCH(NCH), .AW(AW)) u_dec1 (
    .valid(c1_valid), .write(c1_write), .addr(c1_addr),
    .acq(acq1), .wr(wr1), .rel(rel1), .set(set1), .clr(clr1));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mbx_chan #(.DW(DW), .IDW(IDW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .acq0(acq0[n]), .acq1(acq1[n]), .wr0(wr0[n]), .wr1(wr1[n]),
      .rel0(rel0[n]), .rel1(rel1[n]), .id0(c0_id), .id1(c1_id),
      .wdata0(c0_wdata), .wdata1(c1_wdata),
      .grant0(grant0[n]), .grant1(grant1[n]),
      .locked(locked[n]), .owner(owner[n]), .data(data[n]));
  end

  mbx_notify #(.NCH(NCH)) u_ntf (
    .clk(clk), .rst_n(rst_n), .set0(set0), .set1(set1),
    .clr0(clr0), .clr1(clr1), .pend0(irq_c0), .pend1(irq_c1));

  function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] a,
                                            input logic g,
                                            input logic [NCH-1:0] pend);
    logic [3:0]    rg;
    logic [IW-1:0] ix;
    logic [DW-1:0] w;
    rg = a[AW-1:IW];
    ix = a[IW-1:0];
    w  = '0;
    case (rg)
      RG_ACQ:  w[DW-1] = g;
      RG_DATA: w = data[ix];
      RG_STAT: begin
        w[DW-1]    = locked[ix];
        w[IDW-1:0] = owner[ix];
      end
      RG_MAP:  w[NCH-1:0] = locked;
      RG_CLR:  w[NCH-1:0] = pend;
      default: w = '0;
    endcase
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0_rvalid <= 1'b0;
      c1_rvalid <= 1'b0;
      c0_rdata  <= '0;
      c1_rdata  <= '0;
    end else begin
      c0_rvalid <= c0_valid && !c0_write;
      c1_rvalid <= c1_valid && !c1_write;
      c0_rdata  <= (c0_valid && !c0_write) ? rd_word(c0_addr, |grant0, irq_c0) : '0;
      c1_rdata  <= (c1_valid && !c1_write) ? rd_word(c1_addr, |grant1, irq_c1) : '0;
    end
  end

  a_r1_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_valid && !c0_write) |=> c0_rvalid);
  a_r1_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_valid && c1_write) |=> !c1_rvalid);
endmodule

// File: tb/mbx_array_test.sv
`timescale 1ns/1ps
module mbx_array_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        c0_valid = 0, c0_write = 0, c1_valid = 0, c1_write = 0;
  logic [7:0]  c0_addr = 0, c1_addr = 0;
  logic [31:0] c0_wdata = 0, c1_wdata = 0;
  logic [3:0]  c0_id = 0, c1_id = 0;
  logic        c0_rvalid, c1_rvalid;
  logic [31:0] c0_rdata, c1_rdata;
  logic [15:0] irq_c0, irq_c1;

  mbx_array uut (
    .clk(clk), .rst_n(rst_n),
    .c0_valid(c0_valid), .c0_write(c0_write), .c0_addr(c0_addr),
    .c0_wdata(c0_wdata), .c0_id(c0_id), .c0_rvalid(c0_rvalid), .c0_rdata(c0_rdata),
    .c1_valid(c1_valid), .c1_write(c1_write), .c1_addr(c1_addr),
    .c1_wdata(c1_wdata), .c1_id(c1_id), .c1_rvalid(c1_rvalid), .c1_rdata(c1_rdata),
    .irq_c0(irq_c0), .irq_c1(irq_c1));

  int checks = 0;
  int errors = 0;

  bit          m_lock [16];
  logic [3:0]  m_own  [16];
  logic [31:0] m_data [16];
  logic [15:0] m_p0, m_p1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] rg);
    case (rg)
      4'd0: return "R1";
      4'd1: return "R4";
      4'd4: return "R8";
      4'd5, 4'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input bit g, input logic [15:0] p);
    logic [31:0] w;
    w = 0;
    case (a[7:4])
      4'd0: w[31] = g;
      4'd1: w = m_data[a[3:0]];
      4'd4: w[15:0] = p;
      4'd5: begin w[31] = m_lock[a[3:0]]; w[3:0] = m_own[a[3:0]]; end
      4'd6: for (int k = 0; k < 16; k++) w[k] = m_lock[k];
      default: w = 0;
    endcase
    return w;
  endfunction

  // one cycle: called at a falling edge, returns at the next falling edge
  task automatic op(input bit v0, input bit w0, input logic [7:0] a0, input logic [31:0] d0, input logic [3:0] i0,
                    input bit v1, input bit w1, input logic [7:0] a1, input logic [31:0] d1, input logic [3:0] i1,
                    input string tag);
    bit acq0, acq1, g0, g1, own0, own1;
    logic [3:0] x0, x1;
    logic [31:0] e0, e1;
    logic [15:0] s0, s1, k0, k1;
    c0_valid = v0; c0_write = w0; c0_addr = a0; c0_wdata = d0; c0_id = i0;
    c1_valid = v1; c1_write = w1; c1_addr = a1; c1_wdata = d1; c1_id = i1;
    x0 = a0[3:0]; x1 = a1[3:0];
    acq0 = v0 && !w0 && a0[7:4] == 0;
    acq1 = v1 && !w1 && a1[7:4] == 0;
    g0 = acq0 && !m_lock[x0];
    g1 = acq1 && !m_lock[x1] && !(acq0 && x0 == x1);
    e0 = exp_rd(a0, g0, m_p0);
    e1 = exp_rd(a1, g1, m_p1);
    own0 = m_lock[x0] && m_own[x0] == i0;
    own1 = m_lock[x1] && m_own[x1] == i1;
    s0 = 0; s1 = 0; k0 = 0; k1 = 0;
    if (v0 && w0 && a0[7:4] == 3) s0[x0] = 1;
    if (v1 && w1 && a1[7:4] == 3) s1[x1] = 1;
    if (v0 && w0 && a0[7:4] == 4) k0[x0] = 1;
    if (v1 && w1 && a1[7:4] == 4) k1[x1] = 1;
    if (v1 && w1 && a1[7:4] == 1 && own1) m_data[x1] = d1;
    if (v0 && w0 && a0[7:4] == 1 && own0) m_data[x0] = d0;
    if (v0 && w0 && a0[7:4] == 2 && own0) begin m_lock[x0] = 0; m_own[x0] = 0; end
    if (v1 && w1 && a1[7:4] == 2 && own1) begin m_lock[x1] = 0; m_own[x1] = 0; end
    if (g0) begin m_lock[x0] = 1; m_own[x0] = i0; end
    if (g1) begin m_lock[x1] = 1; m_own[x1] = i1; end
    m_p0 = s1 | (m_p0 & ~k0);
    m_p1 = s0 | (m_p1 & ~k1);
    @(negedge clk);
    chk("R1", {31'd0, c0_rvalid}, {31'd0, v0 && !w0});
    chk("R1", {31'd0, c1_rvalid}, {31'd0, v1 && !w1});
    if (v0 && !w0) chk(tag != "" ? tag : tag_of(a0[7:4]), c0_rdata, e0);
    if (v1 && !w1) chk(tag != "" ? tag : tag_of(a1[7:4]), c1_rdata, e1);
    chk("R7", {16'd0, irq_c0}, {16'd0, m_p0});
    chk("R7", {16'd0, irq_c1}, {16'd0, m_p1});
  endtask

  task automatic idle();
    op(0,0,0,0,0, 0,0,0,0,0, "");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int k = 0; k < 16; k++) begin m_lock[k] = 0; m_own[k] = 0; m_data[k] = 0; end
    m_p0 = 0; m_p1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    op(1,0,8'h60,0,1, 1,0,8'h55,0,2, "R9");
    op(1,0,8'h1A,0,1, 1,0,8'h40,0,2, "R9");
    // R1 acquire, R2 held channel refuses even its owner
    op(1,0,8'h02,0,1, 0,0,0,0,0, "R1");
    op(0,0,0,0,0, 1,0,8'h02,0,2, "R2");
    op(1,0,8'h02,0,1, 0,0,0,0,0, "R2");
    op(1,0,8'h52,0,1, 0,0,0,0,0, "R6");
    // R4 foreign write ignored, owner write kept
    op(0,0,0,0,0, 1,1,8'h12,32'h1111_2222,2, "");
    op(0,0,0,0,0, 1,0,8'h12,0,2, "R4");
    op(1,1,8'h12,32'hCAFE_F00D,1, 1,1,8'h12,32'h0BAD_0BAD,2, "");
    op(0,0,0,0,0, 1,0,8'h12,0,2, "R4");
    // R5 release
    op(0,0,0,0,0, 1,1,8'h22,0,2, "");
    op(1,0,8'h52,0,1, 0,0,0,0,0, "R5");
    op(1,1,8'h22,0,1, 0,0,0,0,0, "");
    op(1,0,8'h52,0,1, 1,0,8'h60,0,2, "R5");
    // R3 tie on free channel 7
    op(1,0,8'h07,0,1, 1,0,8'h07,0,2, "R3");
    op(0,0,0,0,0, 1,0,8'h57,0,2, "R3");
    op(1,1,8'h27,0,1, 0,0,0,0,0, "");
    // R7 / R8 notify lines
    op(1,1,8'h34,0,1, 0,0,0,0,0, "");
    idle(); idle();
    op(0,0,0,0,0, 1,0,8'h40,0,2, "R8");
    op(0,0,0,0,0, 1,1,8'h44,0,2, "");
    op(1,1,8'h39,0,1, 1,1,8'h49,0,2, "");
    op(0,0,0,0,0, 1,0,8'h4F,0,2, "R8");
    op(0,0,0,0,0, 1,1,8'h3C,0,2, "");
    op(1,0,8'h40,0,1, 1,1,8'h49,0,2, "R8");
    // R9 writes to acquire/status regions, reads of release/set
    op(1,1,8'h03,32'hFFFF_FFFF,1, 1,1,8'h53,32'hFFFF_FFFF,2, "");
    op(1,0,8'h53,0,1, 1,0,8'h23,0,2, "R9");
    op(1,0,8'h33,0,1, 1,0,8'h73,0,2, "R9");
    // constrained random traffic on a few channels
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] a0, a1;
      bit v0, v1, w0, w1;
      v0 = ($urandom % 5) != 0; v1 = ($urandom % 5) != 0;
      w0 = $urandom % 2; w1 = $urandom % 2;
      a0 = {4'($urandom % 8), 4'($urandom % 4)};
      a1 = {4'($urandom % 8), 4'($urandom % 4)};
      op(v0, w0, a0, $urandom, 4'(1 + $urandom % 3),
         v1, w1, a1, $urandom, 4'(1 + $urandom % 3), "");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule